// File: doc/BRIEF.md
# Event-Triggered Command String Transmitter

This block sends a fixed eleven-character modem command, `AT+CMGR=loc`, over a serial line each time a message-arrival indication from the modem goes high. The command is held as an 88-bit constant. A sequencer hands it to an internal UART transmitter one byte at a time. Each byte goes out with a one-cycle load strobe, and the sequencer waits for the transmitter's completion pulse before it offers the next byte.

The transmitter runs from a free-running baud tick derived from the system clock. The defaults are a 4 MHz clock and 9600 baud. A loaded byte does not start until the next tick, so every bit boundary on the line falls on that tick grid. While a burst is in progress the block reports busy. When the eleventh byte is done it gives a one-cycle completion pulse and returns to idle.

Top module: `cmd_burst_sender`

## Requirements
- R1: During and right after reset, the serial line is high (idle), busy is low and the completion pulse is low.
- R2: A low-to-high change of the arrival input, seen while idle, starts a burst. Busy is high in the clock cycle that follows the first rising clock edge at which the input is seen high.
- R3: A burst carries exactly eleven bytes, the ASCII codes of `A`,`T`,`+`,`C`,`M`,`G`,`R`,`=`,`l`,`o`,`c` in that order. The first byte is bits [87:80] of the command constant and the last is bits [7:0].
- R4: Each byte is framed as one low start bit, eight data bits least significant bit first and one high stop bit. Every bit lasts CLK_HZ/BAUD clock cycles (integer division).
- R5: A byte is never loaded while the previous frame is still on the line, so each stop bit lasts its full bit time. The line is high whenever the transmitter is idle.
- R6: After the eleventh stop bit ends, the completion output is high for exactly one cycle. Busy is low in that same cycle.
- R7: Rising edges of the arrival input that occur during a burst are ignored. They neither add bytes nor start a second burst afterwards.
- R8: Arrival is edge-triggered. An input that stays high after a burst completes starts nothing new until it has gone low and risen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_arrived | input | 1 | Modem indication that a new message is stored; its rising edge triggers a burst |
| tx_serial | output | 1 | Serial transmit line, idle high |
| busy | output | 1 | High while a burst is in progress |
| done_pulse | output | 1 | One-cycle pulse when the last byte has been sent |

## Verification
Busy is due one cycle after the arrival edge is registered, so the bench raises the input at a falling clock edge and reads busy at the next falling edge. Serial bits are sampled at mid-bit. The bench finds the start bit, moves half a bit time to its middle, then steps one full bit time for each data bit and for the stop bit. The completion pulse follows the end of the last stop bit by a couple of cycles, so the bench polls for it in a bounded window, checks busy in the same cycle and checks that the pulse has dropped one cycle later. For the ignored-edge and level-held cases, the bench watches the line and busy over a long quiet window after completion.

// File: rtl/cmd_burst_pkg.sv
package cmd_burst_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ARMED,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_WAIT
    } seq_state_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } byte_load_t;

endpackage

// File: rtl/cmd_baud_tick.sv
module cmd_baud_tick #(
    parameter int DIV = 416
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/cmd_uart_tx.sv
module cmd_uart_tx
    import cmd_burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  byte_load_t load,
    output logic       line,
    output logic       idle,
    output logic       done
);
    localparam int BW = $clog2(BYTE_W);

    tx_state_t         st;
    logic [BYTE_W-1:0] shreg;
    logic [BW-1:0]     bitn;

    assign idle = (st == TX_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= TX_IDLE;
            line  <= 1'b1;
            done  <= 1'b0;
            shreg <= '0;
            bitn  <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                TX_IDLE: if (load.valid) begin
                    shreg <= load.data;
                    st    <= TX_ARMED;
                end
                TX_ARMED: if (tick) begin
                    line <= 1'b0;
                    st   <= TX_START;
                end
                TX_START: if (tick) begin
                    line  <= shreg[0];
                    shreg <= shreg >> 1;
                    bitn  <= '0;
                    st    <= TX_DATA;
                end
                TX_DATA: if (tick) begin
                    if (bitn == BW'(BYTE_W - 1)) begin
                        line <= 1'b1;
                        st   <= TX_STOP;
                    end else begin
                        line  <= shreg[0];
                        shreg <= shreg >> 1;
                        bitn  <= bitn + 1'b1;
                    end
                end
                TX_STOP: if (tick) begin
                    done <= 1'b1;
                    st   <= TX_IDLE;
                end
                default: st <= TX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_byte_sequencer.sv
module cmd_byte_sequencer
    import cmd_burst_pkg::*;
#(
    parameter int                        N_CHARS = 11,
    parameter logic [8*N_CHARS-1:0]      CMD     = "AT+CMGR=loc",
    localparam int                       IDX_W   = $clog2(N_CHARS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    input  logic             tx_done,
    output byte_load_t       load,
    output logic             busy,
    output logic             finished,
    output logic [IDX_W-1:0] idx
);
    seq_state_t st;
    logic       trig_q;
    logic       start;

    function automatic logic [BYTE_W-1:0] pick(input logic [IDX_W-1:0] i);
        return CMD[BYTE_W*(N_CHARS-1-int'(i)) +: BYTE_W];
    endfunction

    assign start      = trigger && !trig_q && (st == SQ_IDLE);
    assign load.valid = (st == SQ_LOAD);
    assign load.data  = pick(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= SQ_IDLE;
            trig_q   <= 1'b0;
            idx      <= '0;
            busy     <= 1'b0;
            finished <= 1'b0;
        end else begin
            trig_q   <= trigger;
            finished <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    idx  <= '0;
                    busy <= 1'b1;
                    st   <= SQ_LOAD;
                end
                SQ_LOAD: st <= SQ_WAIT;
                SQ_WAIT: if (tx_done) begin
                    if (idx == IDX_W'(N_CHARS - 1)) begin
                        busy     <= 1'b0;
                        finished <= 1'b1;
                        st       <= SQ_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= SQ_LOAD;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmd_burst_sender.sv
module cmd_burst_sender
    import cmd_burst_pkg::*;
#(
    parameter int CLK_HZ  = 4_000_000,
    parameter int BAUD    = 9600,
    parameter int N_CHARS = 11,
    parameter logic [8*N_CHARS-1:0] CMD = "AT+CMGR=loc"
) (
    input  logic clk,
    input  logic rst,
    input  logic msg_arrived,
    output logic tx_serial,
    output logic busy,
    output logic done_pulse
);
    localparam int DIV   = CLK_HZ / BAUD;
    localparam int IDX_W = $clog2(N_CHARS);

    logic             tick;
    byte_load_t       load;
    logic             tx_idle;
    logic             tx_done;
    logic [IDX_W-1:0] seq_idx;

    cmd_baud_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    cmd_byte_sequencer #(.N_CHARS(N_CHARS), .CMD(CMD)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .trigger  (msg_arrived),
        .tx_done  (tx_done),
        .load     (load),
        .busy     (busy),
        .finished (done_pulse),
        .idx      (seq_idx)
    );

    cmd_uart_tx u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .load (load),
        .line (tx_serial),
        .idle (tx_idle),
        .done (tx_done)
    );
endmodule

// File: rtl/cmd_burst_checker.sv
module cmd_burst_checker #(
    parameter int N_CHARS = 11,
    parameter int IDX_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             msg_arrived,
    input logic             tx_serial,
    input logic             busy,
    input logic             done_pulse,
    input logic             ld_valid,
    input logic             tx_idle,
    input logic [IDX_W-1:0] seq_idx
);
    // R1: state right after a reset cycle
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (tx_serial && !busy && !done_pulse));

    // R2: a burst only begins after the arrival input was high
    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(msg_arrived));

    // R3: byte index stays inside the command
    assert_index_range_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (int'(seq_idx) < N_CHARS));

    // R5: no load while a frame is still on the line
    assert_load_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> tx_idle);

    // R5: idle transmitter keeps the line high
    assert_idle_high_R5: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> tx_serial);

    // R6: completion is a single cycle and ends a burst
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    assert_done_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (!busy && $past(busy)));
endmodule

bind cmd_burst_sender cmd_burst_checker #(.N_CHARS(N_CHARS), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .msg_arrived (msg_arrived),
    .tx_serial   (tx_serial),
    .busy        (busy),
    .done_pulse  (done_pulse),
    .ld_valid    (load.valid),
    .tx_idle     (tx_idle),
    .seq_idx     (seq_idx)
);

// File: tb/cmd_burst_sender_test.sv
`timescale 1ns/1ps
module cmd_burst_sender_test;
    localparam int CLK_HZ = 96_000;
    localparam int BAUD   = 9600;
    localparam int DIV    = CLK_HZ / BAUD;
    localparam int NCH    = 11;
    localparam logic [8*NCH-1:0] EXPECT_STR = "AT+CMGR=loc";

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic msg_arrived = 1'b0;
    logic tx_serial;
    logic busy;
    logic done_pulse;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cmd_burst_sender #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) uut (
        .clk         (clk),
        .rst         (rst),
        .msg_arrived (msg_arrived),
        .tx_serial   (tx_serial),
        .busy        (busy),
        .done_pulse  (done_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic nclk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Decode one frame; returns received byte and frame validity
    task automatic get_byte(output logic [7:0] b, output bit frame_ok, output bit found);
        int waited = 0;
        b = '0;
        frame_ok = 1'b1;
        found = 1'b0;
        while (tx_serial !== 1'b0 && waited < 40 * DIV) begin
            @(negedge clk);
            waited++;
        end
        if (tx_serial !== 1'b0) return;
        found = 1'b1;
        nclk(DIV / 2);
        if (tx_serial !== 1'b0) frame_ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            nclk(DIV);
            b[i] = tx_serial;
        end
        nclk(DIV);
        if (tx_serial !== 1'b1) frame_ok = 1'b0;
    endtask

    task automatic receive_burst(input string tag);
        logic [7:0] b;
        bit fok, fnd;
        int waited;
        for (int k = 0; k < NCH; k++) begin
            get_byte(b, fok, fnd);
            check(fnd, "R3", {tag, " byte present"}, k, k);
            check(fok, "R4", {tag, " frame start/stop"}, int'(fok), 1);
            check(b === EXPECT_STR[8*(NCH-1-k) +: 8], "R3", {tag, " byte value"},
                  int'(b), int'(EXPECT_STR[8*(NCH-1-k) +: 8]));
            if (k != NCH - 1)
                check(busy === 1'b1, "R6", {tag, " busy mid burst"}, int'(busy), 1);
        end
        waited = 0;
        while (done_pulse !== 1'b1 && waited < 2 * DIV) begin
            @(negedge clk);
            waited++;
        end
        check(done_pulse === 1'b1, "R6", {tag, " completion pulse"}, int'(done_pulse), 1);
        check(busy === 1'b0, "R6", {tag, " busy low with completion"}, int'(busy), 0);
        @(negedge clk);
        check(done_pulse === 1'b0, "R6", {tag, " completion one cycle"}, int'(done_pulse), 0);
    endtask

    task automatic quiet_window(input string req, input string tag, input int n);
        bit moved = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_serial !== 1'b1 || busy !== 1'b0 || done_pulse !== 1'b0) moved = 1'b1;
        end
        check(!moved, req, {tag, " line stays quiet"}, int'(moved), 0);
    endtask

    task automatic test_reset;
        nclk(3);
        check(tx_serial === 1'b1, "R1", "line idle in reset", int'(tx_serial), 1);
        check(busy === 1'b0, "R1", "busy low in reset", int'(busy), 0);
        check(done_pulse === 1'b0, "R1", "done low in reset", int'(done_pulse), 0);
        rst = 1'b0;
        nclk(2);
        check(tx_serial === 1'b1 && busy === 1'b0, "R1", "idle after reset",
              int'({tx_serial, busy}), 2);
    endtask

    task automatic test_single_burst;
        check(busy === 1'b0, "R2", "busy low before trigger", int'(busy), 0);
        msg_arrived = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R2", "busy one cycle after edge", int'(busy), 1);
        msg_arrived = 1'b0;
        receive_burst("single");
        quiet_window("R7", "after single", 20 * DIV);
    endtask

    task automatic test_retrigger_ignored;
        msg_arrived = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R2", "second burst starts", int'(busy), 1);
        fork
            receive_burst("retrig");
            begin
                for (int p = 0; p < 20; p++) begin
                    nclk(7);
                    msg_arrived = 1'b0;
                    nclk(8);
                    msg_arrived = 1'b1;
                end
                msg_arrived = 1'b0;
            end
        join
        quiet_window("R7", "edges during burst ignored", 30 * DIV);
    endtask

    task automatic test_level_held;
        msg_arrived = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R8", "held level starts burst", int'(busy), 1);
        receive_burst("held");
        quiet_window("R8", "held level no retrigger", 30 * DIV);
        msg_arrived = 1'b0;
        nclk(3);
        msg_arrived = 1'b1;
        @(negedge clk);
        check(busy === 1'b1, "R8", "new edge after low starts burst", int'(busy), 1);
        msg_arrived = 1'b0;
        receive_burst("rearm");
    endtask

    initial begin
        test_reset();
        test_single_burst();
        test_retrigger_ignored();
        test_level_held();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule